// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master of an Ethernet MAC subsystem. Software hands it one 32-bit command word. The block then clocks a complete management frame out on the MDC/MDIO pair and reports completion through a busy flag. That flag is bit 31 of a status word, and software polls it. For read frames, the 16 data bits returned by the PHY appear in the low half of the same status word once busy drops.

The start-of-frame code and the opcode are passed into the frame unchanged. The same engine therefore issues both kinds of frame:

- Clause 22 frames (start code 01).
- Clause 45 frames (start code 00). A Clause 45 register access is two commands in a row. The first is an address frame. The second, issued after busy clears, is a read or write frame with the same port and device address.

MDC is divided down from the system clock and stays high between frames. The master changes MDIO only just after a falling MDC edge, and it samples read data on rising MDC edges.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, busy (status bit 31) is 0, `mdio_oe` is 0 and `mdc` is 1.
- R2: A command write with bit 31 set, while busy is 0, sets busy in the cycle after the write.
- R3: A frame is serialised MSB first, one bit per MDC period, in this order:
  - 32 preamble ones;
  - start code = command bits 17:16;
  - opcode = command bits 19:18;
  - port address = command bits 24:20;
  - register/device address = command bits 29:25;
  - a 2-bit turnaround, driven as 1 then 0 on non-read frames;
  - 16 data bits = command bits 15:0.
- R4: On a read frame (opcode bit 19 = 1, that is opcode 10 or 11), `mdio_oe` is 0 from the first turnaround bit to the end of the frame. The 16 bits sampled after turnaround, first sampled = bit 15, appear in status bits 15:0 when busy clears. Frames that are not reads leave status bits 15:0 unchanged.
- R5: MDC is high whenever the block is idle. During a frame, each MDC half period lasts `HALF_DIV` system clocks. MDIO changes only on the system clock edge at which MDC falls, or at the start of a frame.
- R6: Busy stays set for exactly 2·(`PRE_BITS`+32)·`HALF_DIV` system clocks. With the defaults this is 2560.
- R7: A command write while busy is set is ignored. The running frame continues unchanged and no further frame follows.
- R8: Clause 45 frames use start code 00. Opcode 00 is an address frame and opcode 11 is a read, and each is carried exactly as written.
- R9: A command write with bit 31 clear starts nothing. Busy stays 0 and MDC stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command-word write strobe |
| cmd_word | input | 32 | Command word (go, fields, data) |
| stat_word | output | 32 | Bit 31 busy, bits 15:0 last read data, others 0 |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
Busy is due one system clock after the command write. It must then stay set for exactly 2560 clocks, which the bench counts at falling system-clock edges. Frame bits are taken at the system-clock sample just after each MDC fall. The k-th such sample holds frame bit k, and the spacing between samples must be 2·`HALF_DIV` clocks. The read result and the idle MDC/enable state are checked at the first sample after busy drops. A scoreboard pairs each observed 64-bit frame with the expected one that the driver queued.

// File: rtl/mdio_pkg.sv
// Shared types for the MDIO master: the decoded command fields and
// the helpers that unpack a 32-bit command word.
package mdio_pkg;

    localparam int GO_BIT = 31;

    typedef struct packed {
        logic [1:0]  st;     // start-of-frame code
        logic [1:0]  op;     // opcode
        logic [4:0]  phy;    // port address
        logic [4:0]  reg_a;  // register or device address
        logic [15:0] data;   // write data or Clause 45 register address
    } mdio_cmd_t;

    // Unpack the command word into its fields.
    function automatic mdio_cmd_t decode_cmd(input logic [31:0] w);
        mdio_cmd_t c;
        c.st    = w[17:16];
        c.op    = w[19:18];
        c.phy   = w[24:20];
        c.reg_a = w[29:25];
        c.data  = w[15:0];
        return c;
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
// MDC generator. While run is high it toggles mdc every HALF_DIV system
// clocks and flags the cycle on which mdc falls or rises. While run is
// low mdc is held high and the phase counter is cleared.
// Assumes HALF_DIV >= 2.
module mdio_clk_gen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic fall_tk,
    output logic rise_tk
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap    = run && (cnt == LAST);
    assign fall_tk = wrap && mdc;
    assign rise_tk = wrap && !mdc;

    // Phase counter and mdc toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b1;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: mdc only moves on a counter wrap.
    assert_mdc_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$stable(mdc)) |-> $past(wrap));

endmodule

// File: rtl/mdio_frame_eng.sv
// Frame engine. It loads one management frame into a shift register on
// start, shifts a new bit out after each falling MDC edge (after the first
// rise has been seen), releases MDIO from turnaround on read frames,
// samples read data on rising edges, and clears busy after the last rise.
// Assumes the start pulse is ignored by the caller's intent while busy.
module mdio_frame_eng
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        fall_tk,
    input  logic        rise_tk,
    input  logic        mdio_in,
    output logic        busy,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    localparam int FRAME_BITS = PRE_BITS + 32;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + 14);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_BITS + 16);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sreg;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W-1:0]      idx_nxt;
    logic [15:0]           cap;
    logic                  is_rd;
    logic                  primed;
    logic [FRAME_BITS-1:0] frame;

    // Assemble the serial frame from the command fields.
    always_comb begin
        frame = {{PRE_BITS{1'b1}}, cmd.st, cmd.op, cmd.phy, cmd.reg_a,
                 (cmd.op[1] ? 2'b11 : 2'b10), cmd.data};
    end

    assign idx_nxt  = idx + 1'b1;
    assign mdio_out = sreg[FRAME_BITS-1];

    // Frame sequencing: load, shift on fall, capture on rise, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sreg    <= '0;
            idx     <= '0;
            cap     <= '0;
            is_rd   <= 1'b0;
            primed  <= 1'b0;
            mdio_oe <= 1'b0;
            rd_data <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                sreg    <= frame;
                idx     <= '0;
                cap     <= '0;
                is_rd   <= cmd.op[1];
                primed  <= 1'b0;
                mdio_oe <= 1'b1;
            end
        end else if (rise_tk) begin
            primed <= 1'b1;
            if (is_rd && idx >= DATA_IDX)
                cap <= {cap[14:0], mdio_in};
            if (idx == LAST_IDX) begin
                busy    <= 1'b0;
                mdio_oe <= 1'b0;
                if (is_rd)
                    rd_data <= {cap[14:0], mdio_in};
            end
        end else if (fall_tk && primed) begin
            sreg <= sreg << 1;
            idx  <= idx_nxt;
            if (is_rd && idx_nxt == TA_IDX)
                mdio_oe <= 1'b0;
        end
    end

    // R5: the driven bit changes only after a falling MDC edge.
    assert_out_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mdio_out)) |-> $past(fall_tk));

    // R4: a read frame never drives from turnaround onward.
    assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_rd && idx >= TA_IDX) |-> !mdio_oe);

    // R7: a start while busy does not rewind the frame.
    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (idx >= $past(idx)));

    // R2: an accepted start raises busy on the next cycle.
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R4: read data only changes when a frame ends.
    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_data)) |-> ($past(busy) && !busy));

endmodule

// File: rtl/mdio_master.sv
// MDIO management master top. A command write with bit 31 set, while
// idle, starts one Clause 22 or Clause 45 frame whose start code and
// opcode are taken verbatim from the command word. Status bit 31 is busy,
// and bits 15:0 hold the last read result.
// Assumes a synchronous active-low reset and an external pull-up on MDIO.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 20,
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_word,
    output logic [31:0] stat_word,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    localparam int BUSY_CYC = 2 * (PRE_BITS + 32) * HALF_DIV;

    logic        busy;
    logic        start;
    logic        fall_tk;
    logic        rise_tk;
    logic [15:0] rd_data;
    mdio_cmd_t   cmd;

    assign start     = cmd_wr && cmd_word[GO_BIT];
    assign cmd       = decode_cmd(cmd_word);
    assign stat_word = {busy, 15'b0, rd_data};

    mdio_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .mdc(mdc), .fall_tk(fall_tk), .rise_tk(rise_tk)
    );

    mdio_frame_eng #(.PRE_BITS(PRE_BITS)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .fall_tk(fall_tk), .rise_tk(rise_tk), .mdio_in(mdio_in),
        .busy(busy), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .rd_data(rd_data)
    );

    // Busy-length counter for the R6 check.
    logic [31:0] len_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) len_cnt <= '0;
        else                 len_cnt <= len_cnt + 1'b1;
    end

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (len_cnt == 32'(BUSY_CYC)));

    // R5: MDC is high whenever no frame is running.
    assert_mdc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mdc);

    // R1: the cycle after reset shows the idle state.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !mdio_oe && mdc));

    // R9: a write without the go bit does not start a frame.
    assert_no_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && !cmd_word[GO_BIT]) |=> !busy);

endmodule

// File: tb/mdio_master_bench.sv
// Scoreboard bench: the driver queues expected frames; the monitor
// rebuilds each frame from the pins and compares it with the queue head.
module mdio_master_bench;
    localparam int HALF = 20;
    localparam int BUSY_LEN = 2 * 64 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] stat_word;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int total = 0;
    int bad = 0;

    logic [63:0] exp_q[$];
    bit          rdq[$];
    logic [15:0] resp_cur = '0;
    bit          rd_cur = 0;

    always #5 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF), .PRE_BITS(32)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .stat_word(stat_word), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: one sample per MDC fall; sample k is frame bit k.
    int          k = 0;
    int          gap = 0;
    bit          gap_bad = 0;
    logic        prev_mdc = 1'b1;
    logic [63:0] obits = '0;
    logic [63:0] oes = '0;
    always @(negedge clk) begin
        gap++;
        if (rst_n && prev_mdc && !mdc) begin
            if (k != 0 && gap != 2 * HALF) gap_bad = 1;
            gap = 0;
            obits[63-k] = mdio_out;
            oes[63-k]   = mdio_oe;
            mdio_in = (rd_cur && k >= 48) ? resp_cur[63-k] : 1'b1;
            k++;
            if (k == 64) begin
                k = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected extra frame", obits, 64'h0);
                end else begin
                    logic [63:0] ef;
                    logic [63:0] em;
                    bit          rd;
                    ef = exp_q.pop_front();
                    rd = rdq.pop_front();
                    em = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
                    chk(((obits ^ ef) & em) == 0, "R3/R8 frame bits", obits, ef);
                    chk(oes == em, "R4 output enable pattern", oes, em);
                    chk(!gap_bad, "R5 MDC period", 64'(gap_bad), 64'h0);
                end
                gap_bad = 0;
            end
        end
        prev_mdc = mdc;
    end

    // Driver: issue one command, queue its frame, time busy, check results.
    task automatic issue(input logic [31:0] w, input logic [15:0] resp,
                         input bit poke);
        logic [63:0] ef;
        logic [15:0] prev;
        int cnt;
        ef = {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25],
              (w[19] ? 2'b11 : 2'b10), w[15:0]};
        exp_q.push_back(ef);
        rdq.push_back(w[19]);
        resp_cur = resp;
        rd_cur = w[19];
        @(negedge clk);
        prev = stat_word[15:0];
        cmd_wr = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(stat_word[31] == 1'b1, "R2 busy after write", 64'(stat_word[31]), 64'h1);
        cnt = 0;
        while (stat_word[31] && cnt < BUSY_LEN + 100) begin
            cnt++;
            if (poke && cnt == 300) begin
                cmd_wr = 1'b1;
                cmd_word = ~w | 32'h8000_0000;
            end else begin
                cmd_wr = 1'b0;
            end
            @(negedge clk);
        end
        cmd_wr = 1'b0;
        chk(cnt == BUSY_LEN, "R6 busy length", 64'(cnt), 64'(BUSY_LEN));
        if (w[19])
            chk(stat_word[15:0] == resp, "R4 read data", 64'(stat_word[15:0]), 64'(resp));
        else
            chk(stat_word[15:0] == prev, "R4 data kept on non-read", 64'(stat_word[15:0]), 64'(prev));
        chk(mdc == 1'b1 && mdio_oe == 1'b0, "R5 idle mdc high, released",
            {62'h0, mdc, mdio_oe}, 64'h2);
        repeat (60) @(negedge clk);
        if (poke)
            chk(stat_word[31] == 1'b0, "R7 write while busy ignored", 64'(stat_word[31]), 64'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(stat_word[31] == 1'b0, "R1 busy at reset", 64'(stat_word[31]), 64'h0);
        chk(mdio_oe == 1'b0, "R1 oe at reset", 64'(mdio_oe), 64'h0);
        chk(mdc == 1'b1, "R1 mdc at reset", 64'(mdc), 64'h1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Clause 22 write: st 01, op 01, port 03, reg 1A
        issue({1'b1, 1'b0, 5'h1A, 5'h03, 2'b01, 2'b01, 16'hA55A}, 16'h0, 0);
        // Clause 22 read: st 01, op 10, port 1F, reg 00
        issue({1'b1, 1'b0, 5'h00, 5'h1F, 2'b10, 2'b01, 16'h0000}, 16'h1234, 0);
        // R8 Clause 45 address frame: st 00, op 00, port 02, dev 1E
        issue({1'b1, 1'b0, 5'h1E, 5'h02, 2'b00, 2'b00, 16'h8001}, 16'h0, 0);
        // R8 Clause 45 read: st 00, op 11
        issue({1'b1, 1'b0, 5'h1E, 5'h02, 2'b11, 2'b00, 16'h0000}, 16'hFEDC, 0);
        // Clause 45 write: st 00, op 01
        issue({1'b1, 1'b0, 5'h1E, 5'h02, 2'b01, 2'b00, 16'h0F0F}, 16'h0, 0);
        // R7 Clause 22 read with a command poked in mid-frame
        issue({1'b1, 1'b0, 5'h11, 5'h15, 2'b10, 2'b01, 16'h0000}, 16'h8421, 1);

        // R9 no go bit
        begin
            bit moved = 0;
            @(negedge clk);
            cmd_wr = 1'b1;
            cmd_word = 32'h7FFF_FFFF;
            @(negedge clk);
            cmd_wr = 1'b0;
            repeat (200) begin
                if (stat_word[31] || !mdc) moved = 1;
                @(negedge clk);
            end
            chk(!moved, "R9 no start without go bit", 64'(moved), 64'h0);
            chk(stat_word[15:0] == 16'h8421, "R7 read result after poke",
                64'(stat_word[15:0]), 64'h8421);
        end

        chk(exp_q.size() == 0, "R3 all frames seen", 64'(exp_q.size()), 64'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule